// File: doc/BRIEF.md
# Posted-Write Memory Controller

This controller sits between a CPU bus and a RAM whose write data and read data travel on separate wires. A CPU store to RAM is captured into a one-entry holding latch and acknowledged on the next clock edge. The controller then drives the RAM write from that latch over several cycles while the CPU moves on to other bus cycles. With the default write length of four cycles, each store costs the CPU one cycle instead of about five.

The latch is the only place a store can wait, so the controller must keep RAM consistent. A RAM read that arrives while a store is still being retired is held until the RAM is free, so it always returns the new data. A second store that finds the latch occupied waits in the same way. Accesses to the non-RAM half of the address space go to a peripheral port. They complete in one edge whatever the latch holds, and they cannot disturb the RAM write in progress.

Top module: `pwc_top`

## Requirements
- R1: A RAM write (cpu_we=1, cpu_addr MSB=0) presented while the latch is empty is acknowledged at the first clock edge. cpu_ack is a one-cycle pulse.
- R2: During a posted write, ram_addr, ram_wdata and ram_be equal the captured cpu_addr (MSB dropped), cpu_wdata and cpu_be. They stay stable while ram_we is high.
- R3: ram_we goes high in the cycle after the write is accepted and stays high for exactly WR_CYC consecutive cycles (default 4).
- R4: A RAM read presented while the latch is empty is acknowledged two edges after it is presented, with the stored word on cpu_rdata. A RAM read presented while a write is pending is accepted only after ram_we has dropped. The stall means it returns the newly written data.
- R5: A RAM write presented while the latch is occupied is not acknowledged until the pending write has retired.
- R6: An access with cpu_addr MSB=1 is acknowledged at the first edge, with ext_sel high in the accept cycle. This holds even while a posted write is pending. For a read, cpu_rdata equals ext_rdata. The access does not alter the pending RAM write.
- R7: After reset, cpu_ack and ram_we are low and the latch is empty.
- R8: Only the byte lanes whose cpu_be bit is 1 are changed in RAM. Bit i of cpu_be covers data bits 8i+7..8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU address; MSB 0 selects RAM |
| cpu_be | input | DATA_W/8 | Byte lane enables for writes |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| ram_addr | output | ADDR_W-1 | RAM word address |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | DATA_W/8 | RAM byte lane enables |
| ram_wdata | output | DATA_W | RAM write data from the latch |
| ram_re | output | 1 | RAM read strobe; data returns one edge later |
| ram_rdata | input | DATA_W | RAM read data |
| ext_sel | output | 1 | Peripheral access accepted this cycle |
| ext_rdata | input | DATA_W | Peripheral read data |

## Verification
A latch that never empties shows up within WR_CYC+2 edges: ram_we fails to drop, and any following RAM read or write never acknowledges. A latch that empties early shows up in the same window as a short write-enable burst, and a read issued right after a write returns stale data. Wrong capture or lane gating shows up on the first read-back, which compares every byte against an independently kept model. A peripheral access that stalls behind a pending write is caught at once as a multi-edge acknowledge.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    localparam int unsigned PWC_ADDR_W_DEF = 16;
    localparam int unsigned PWC_DATA_W_DEF = 32;
    localparam int unsigned PWC_WR_CYC_DEF = 4;

    // Kind of access accepted in the current cycle
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_RAM_WR = 2'd1,
        ACC_RAM_RD = 2'd2,
        ACC_EXT    = 2'd3
    } acc_kind_e;

    // RAM occupies the lower half of the address space
    function automatic logic hits_ram(input logic addr_msb);
        return addr_msb == 1'b0;
    endfunction

endpackage

// File: rtl/pwc_classify.sv
module pwc_classify
    import pwc_pkg::*;
(
    input  logic      cpu_req,
    input  logic      cpu_we,
    input  logic      addr_msb,
    input  logic      latch_busy,
    input  logic      ack_busy,
    input  logic      rd_busy,
    output acc_kind_e kind
);

    logic blocked;

    always_comb begin
        blocked = ack_busy | rd_busy;
        kind    = ACC_NONE;
        if (cpu_req && !blocked) begin
            if (!hits_ram(addr_msb)) begin
                kind = ACC_EXT;
            end else if (!latch_busy) begin
                kind = cpu_we ? ACC_RAM_WR : ACC_RAM_RD;
            end
        end
    end

endmodule

// File: rtl/pwc_wlatch.sv
module pwc_wlatch #(
    parameter int unsigned RAW    = 15,
    parameter int unsigned DW     = 32,
    parameter int unsigned BW     = DW / 8,
    parameter int unsigned WR_CYC = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [RAW-1:0] in_addr,
    input  logic [DW-1:0]  in_data,
    input  logic [BW-1:0]  in_be,
    output logic           busy,
    output logic [RAW-1:0] out_addr,
    output logic [DW-1:0]  out_data,
    output logic [BW-1:0]  out_be
);

    localparam int unsigned CNT_W = $clog2(WR_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYC - 1);

    typedef struct packed {
        logic [RAW-1:0] addr;
        logic [DW-1:0]  data;
        logic [BW-1:0]  be;
    } entry_t;

    entry_t           held;
    logic             valid;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            cnt   <= '0;
            held  <= '0;
        end else if (load) begin
            valid     <= 1'b1;
            cnt       <= '0;
            held.addr <= in_addr;
            held.data <= in_data;
            held.be   <= in_be;
        end else if (valid) begin
            if (cnt == LAST) begin
                valid <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign busy     = valid;
    assign out_addr = held.addr;
    assign out_data = held.data;
    assign out_be   = held.be;

endmodule

// File: rtl/pwc_respond.sv
module pwc_respond
    import pwc_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_kind_e     kind,
    input  logic [DW-1:0] ram_rdata,
    input  logic [DW-1:0] ext_rdata,
    output logic          ack,
    output logic          rd_busy,
    output logic [DW-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack     <= 1'b0;
            rd_busy <= 1'b0;
            rdata   <= '0;
        end else begin
            ack <= 1'b0;
            if (rd_busy) begin
                ack     <= 1'b1;
                rdata   <= ram_rdata;
                rd_busy <= 1'b0;
            end
            unique case (kind)
                ACC_RAM_WR: ack <= 1'b1;
                ACC_EXT: begin
                    ack   <= 1'b1;
                    rdata <= ext_rdata;
                end
                ACC_RAM_RD: rd_busy <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pwc_top.sv
module pwc_top
    import pwc_pkg::*;
#(
    parameter int unsigned ADDR_W = PWC_ADDR_W_DEF,
    parameter int unsigned DATA_W = PWC_DATA_W_DEF,
    parameter int unsigned WR_CYC = PWC_WR_CYC_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W/8-1:0]   cpu_be,
    input  logic [DATA_W-1:0]     cpu_wdata,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  cpu_ack,
    output logic [ADDR_W-2:0]     ram_addr,
    output logic                  ram_we,
    output logic [DATA_W/8-1:0]   ram_be,
    output logic [DATA_W-1:0]     ram_wdata,
    output logic                  ram_re,
    input  logic [DATA_W-1:0]     ram_rdata,
    output logic                  ext_sel,
    input  logic [DATA_W-1:0]     ext_rdata
);

    localparam int unsigned RAW = ADDR_W - 1;
    localparam int unsigned BW  = DATA_W / 8;

    acc_kind_e      kind;
    logic           latch_busy;
    logic           rd_busy;
    logic [RAW-1:0] latch_addr;

    pwc_classify u_classify (
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .addr_msb   (cpu_addr[ADDR_W-1]),
        .latch_busy (latch_busy),
        .ack_busy   (cpu_ack),
        .rd_busy    (rd_busy),
        .kind       (kind)
    );

    pwc_wlatch #(
        .RAW    (RAW),
        .DW     (DATA_W),
        .BW     (BW),
        .WR_CYC (WR_CYC)
    ) u_wlatch (
        .clk      (clk),
        .rst      (rst),
        .load     (kind == ACC_RAM_WR),
        .in_addr  (cpu_addr[RAW-1:0]),
        .in_data  (cpu_wdata),
        .in_be    (cpu_be),
        .busy     (latch_busy),
        .out_addr (latch_addr),
        .out_data (ram_wdata),
        .out_be   (ram_be)
    );

    pwc_respond #(
        .DW (DATA_W)
    ) u_respond (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .ram_rdata (ram_rdata),
        .ext_rdata (ext_rdata),
        .ack       (cpu_ack),
        .rd_busy   (rd_busy),
        .rdata     (cpu_rdata)
    );

    // Reads are only issued with the latch empty, so the address mux never collides
    assign ram_addr = latch_busy ? latch_addr : cpu_addr[RAW-1:0];
    assign ram_we   = latch_busy;
    assign ram_re   = (kind == ACC_RAM_RD);
    assign ext_sel  = (kind == ACC_EXT);

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WR_CYC = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                cpu_ack,
    input logic                ram_we,
    input logic                ram_re,
    input logic [ADDR_W-2:0]   ram_addr,
    input logic [DATA_W-1:0]   ram_wdata,
    input logic [DATA_W/8-1:0] ram_be,
    input logic                ext_sel
);

    logic [31:0] we_run;

    always_ff @(posedge clk) begin
        if (rst) we_run <= '0;
        else     we_run <= ram_we ? we_run + 1 : '0;
    end

    // R1: acknowledge is a single-cycle pulse
    a_r1_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack);

    // R2: write fields hold steady across the write burst
    a_r2_fields_hold: assert property (@(posedge clk) disable iff (rst)
        (ram_we && $past(ram_we)) |->
            ($stable(ram_addr) && $stable(ram_wdata) && $stable(ram_be)));

    // R3: burst never runs past WR_CYC cycles
    a_r3_we_cap: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (we_run < WR_CYC));

    // R3: burst lasts exactly WR_CYC cycles
    a_r3_we_len: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_we) |-> (we_run == WR_CYC));

    // R4: no RAM read while a write is retiring
    a_r4_no_read_in_write: assert property (@(posedge clk) disable iff (rst)
        ram_re |-> !ram_we);

    // R6: peripheral access completes at the next edge
    a_r6_ext_ack: assert property (@(posedge clk) disable iff (rst)
        ext_sel |=> cpu_ack);

    // R7: idle outputs right after reset
    a_r7_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!ram_we && !cpu_ack));

endmodule

bind pwc_top pwc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WR_CYC (WR_CYC)
) u_pwc_checker (
    .clk       (clk),
    .rst       (rst),
    .cpu_ack   (cpu_ack),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_be    (ram_be),
    .ext_sel   (ext_sel)
);

// File: tb/pwc_tb.sv
`timescale 1ns/1ps
module pwc_top_tb_top;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int BW = DW / 8;
    localparam int WR = 4;
    localparam logic [DW-1:0] EXT_WORD = 32'hE0E0_1234;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [BW-1:0] cpu_be = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ack;
    logic [AW-2:0] ram_addr;
    logic          ram_we;
    logic [BW-1:0] ram_be;
    logic [DW-1:0] ram_wdata;
    logic          ram_re;
    logic [DW-1:0] ram_rdata = '0;
    logic          ext_sel;
    logic [DW-1:0] ext_rdata = EXT_WORD;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwc_top #(.ADDR_W(AW), .DATA_W(DW), .WR_CYC(WR)) dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_be(ram_be), .ram_wdata(ram_wdata),
        .ram_re(ram_re), .ram_rdata(ram_rdata), .ext_sel(ext_sel),
        .ext_rdata(ext_rdata)
    );

    // RAM model: separate write and read data, one-edge read latency
    logic [DW-1:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (ram_we)
            for (int b = 0; b < BW; b++)
                if (ram_be[b]) mem[ram_addr[7:0]][8*b +: 8] <= ram_wdata[8*b +: 8];
        if (ram_re) ram_rdata <= mem[ram_addr[7:0]];
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus access; returns edges until ack and the read data
    task automatic access(input logic we, input logic [AW-1:0] a, input logic [BW-1:0] be,
                          input logic [DW-1:0] wd, output int edges, output logic [DW-1:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
        edges = 0;
        do begin
            @(posedge clk); #2;
            edges++;
        end while (!cpu_ack && edges < 100);
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic drain();
        while (ram_we) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R7 ack after reset", 64'(cpu_ack), 64'd0);
        check("R7 we after reset", 64'(ram_we), 64'd0);
    endtask

    task automatic t_write_basic();
        int e; int cnt; logic [DW-1:0] d;
        access(1'b1, 16'h0010, 4'hF, 32'hA5A5_0001, e, d);
        check("R1 write ack latency", 64'(e), 64'd1);
        check("R2 ram_addr", 64'(ram_addr), 64'h10);
        check("R2 ram_wdata", 64'(ram_wdata), 64'hA5A5_0001);
        cnt = 0;
        while (ram_we && cnt < 50) begin cnt++; @(negedge clk); end
        check("R3 we burst length", 64'(cnt), 64'(WR));
        access(1'b0, 16'h0010, 4'h0, '0, e, d);
        check("R4 idle read latency", 64'(e), 64'd2);
        check("R4 idle read data", 64'(d), 64'hA5A5_0001);
    endtask

    task automatic t_byte_enable();
        int e; logic [DW-1:0] d;
        access(1'b1, 16'h0020, 4'hF, 32'h1122_3344, e, d);
        drain();
        access(1'b1, 16'h0020, 4'b0101, 32'hAABB_CCDD, e, d);
        drain();
        access(1'b0, 16'h0020, 4'h0, '0, e, d);
        check("R8 lane merge", 64'(d), 64'h11BB_33DD);
    endtask

    task automatic t_read_stall();
        int e; logic [DW-1:0] d;
        access(1'b1, 16'h0030, 4'hF, 32'hDEAD_BEEF, e, d);
        access(1'b0, 16'h0030, 4'h0, '0, e, d);
        check("R4 stalled read latency", 64'(e), 64'(WR + 1));
        check("R4 stalled read data", 64'(d), 64'hDEAD_BEEF);
    endtask

    task automatic t_write_stall();
        int e; logic [DW-1:0] d;
        access(1'b1, 16'h0040, 4'hF, 32'h0000_4040, e, d);
        access(1'b1, 16'h0041, 4'hF, 32'h0000_4141, e, d);
        check("R5 second write latency", 64'(e), 64'(WR));
        drain();
        access(1'b0, 16'h0040, 4'h0, '0, e, d);
        check("R5 first write kept", 64'(d), 64'h0000_4040);
        access(1'b0, 16'h0041, 4'h0, '0, e, d);
        check("R5 second write kept", 64'(d), 64'h0000_4141);
    endtask

    task automatic t_ext();
        int e; logic [DW-1:0] d;
        access(1'b0, 16'h8005, 4'h0, '0, e, d);
        check("R6 ext read latency idle", 64'(e), 64'd1);
        check("R6 ext read data", 64'(d), 64'(EXT_WORD));
        access(1'b1, 16'h0050, 4'hF, 32'h5050_5050, e, d);
        access(1'b1, 16'h8006, 4'hF, 32'hFFFF_FFFF, e, d);
        check("R6 ext write during pending", 64'(e), 64'd1);
        check("R6 pending write still active", 64'(ram_we), 64'd1);
        check("R6 pending address untouched", 64'(ram_addr), 64'h50);
        check("R6 pending data untouched", 64'(ram_wdata), 64'h5050_5050);
        access(1'b0, 16'h0050, 4'h0, '0, e, d);
        check("R6 RAM data after ext traffic", 64'(d), 64'h5050_5050);
    endtask

    initial begin
        #200_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_basic();
        t_byte_enable();
        t_read_stall();
        t_write_stall();
        t_ext();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule